// File: doc/BRIEF.md
# Fixed-Priority Nesting Interrupt Controller

This block gathers up to 32 external request lines and presents a single interrupt request to a CPU. Each line owns a fixed vector: line n always answers with vector 32+n. A higher line number outranks a lower one. A line that wins is moved into service when the CPU acknowledges it. Further requests are then signalled only when they outrank every line already in service, so handlers nest strictly by priority.

Software configures the block through a simple 32-bit register port with combinational reads. Each line has a configuration entry holding a mask bit and a trigger-mode bit. These entries are reached indirectly, through an index register whose line number is split across two bit fields, and a data window. A global enable bit gates delivery. Writing an end-of-interrupt register retires the most urgent line in service. A read-only status word shows which lines are in service.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset every configuration entry reads 0x00010000 (masked, edge mode), the in-service word reads 0, the enable register reads 0, cpuIrq is low and ackVector is 0xFF.
- R2: The index register sits at 0x000. Line n is selected by an index with n[2:0] in bits 3:1, n[4:3] in bits 6:5 and all other bits zero. An index with bit 0, bit 4 or bit 7 set selects no line: the data window at 0x010 then reads 0 and ignores writes.
- R3: In a configuration entry, bit 16 is the mask (1 = masked) and bit 15 the trigger mode (1 = level, 0 = edge). All other bits are dropped on write and read back as zero.
- R4: Bit 8 of the register at 0x0F0 is the global enable. While it is clear, cpuIrq stays low and intAck has no effect, but edges on unmasked lines are still latched.
- R5: cpuIrq is high while the highest eligible line outranks every line in service, and ackVector then shows 32 plus that line number. Otherwise ackVector is 0xFF. An intAck pulse with cpuIrq high puts that line into service and clears its latched edge.
- R6: A request preempts only when its line number is strictly greater than every line in service. A lower or equal request stays pending without raising cpuIrq.
- R7: Any write to 0x0B0 clears only the highest in-service bit. The next eligible request that outranks what remains is then presented.
- R8: A level-mode line is pending while its sampled input is high and it is not in service. It deasserts once the input falls.
- R9: An edge-mode line latches a pending bit on a rising input only if it is unmasked when the edge is sampled. A masked line's pending bit is never presented.
- R10: The read-only word at 0x110 has bit n set exactly while line n is in service.
- R11: An intAck pulse while cpuIrq is low changes nothing: the in-service word stays the same and ackVector stays 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqLines | input | 32 | External request lines, sampled every clock |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 12 | Register byte address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Combinational read data for regAddr |
| intAck | input | 1 | CPU acknowledge pulse |
| cpuIrq | output | 1 | Interrupt request to the CPU |
| ackVector | output | 8 | Vector of the presented request, 0xFF when none |

## Verification
An input line change is sampled by one register, so its effect on cpuIrq and ackVector appears right after the next rising edge. Writes, acknowledges and end-of-interrupt writes also take effect at that edge. Register reads are combinational and are due in the same cycle as the address. The bench drives inputs just after a falling edge, steps its reference state at the rising edge, and compares outputs at the following falling edge. Reads are sampled a moment after the address settles, with no write pending.

// File: rtl/nic_pkg.sv
package nic_pkg;
  localparam int LINE_W = 5;
  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] ADDR_INDEX  = 12'h000;
  localparam logic [ADDR_W-1:0] ADDR_WINDOW = 12'h010;
  localparam logic [ADDR_W-1:0] ADDR_EOI    = 12'h0B0;
  localparam logic [ADDR_W-1:0] ADDR_ENABLE = 12'h0F0;
  localparam logic [ADDR_W-1:0] ADDR_ISR    = 12'h110;

  localparam int CFG_MASK_BIT  = 16;
  localparam int CFG_LEVEL_BIT = 15;
  localparam int EN_BIT        = 8;

  typedef enum logic [2:0] {
    RD_NONE, RD_INDEX, RD_WINDOW, RD_ENABLE, RD_ISR
  } rdSel_e;

  typedef struct packed {
    logic   idxWr;
    logic   cfgWr;
    logic   enWr;
    logic   eoiWr;
    logic   ackTake;
    rdSel_e rdSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/nic_ctrl.sv
module nic_ctrl
  import nic_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int VEC_BASE  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              intAck,
  input  logic              candValid,
  input  logic [LINE_W-1:0] candIdx,
  input  logic              svcValid,
  input  logic [LINE_W-1:0] svcIdx,
  input  logic              enBit,
  output ctrlStrobe_t       strobe,
  output logic              cpuIrq,
  output logic [7:0]        ackVector
);
  logic irqReq;

  assign irqReq = enBit && candValid && (!svcValid || (candIdx > svcIdx));

  always_comb begin
    strobe         = '0;
    strobe.rdSel   = RD_NONE;
    strobe.ackTake = intAck && irqReq;
    unique case (regAddr)
      ADDR_INDEX: begin
        strobe.idxWr = regWrEn;
        strobe.rdSel = RD_INDEX;
      end
      ADDR_WINDOW: begin
        strobe.cfgWr = regWrEn;
        strobe.rdSel = RD_WINDOW;
      end
      ADDR_ENABLE: begin
        strobe.enWr  = regWrEn;
        strobe.rdSel = RD_ENABLE;
      end
      ADDR_EOI: strobe.eoiWr = regWrEn;
      ADDR_ISR: strobe.rdSel = RD_ISR;
      default: ;
    endcase
  end

  assign cpuIrq    = irqReq;
  assign ackVector = irqReq ? (8'(VEC_BASE) + {{(8-LINE_W){1'b0}}, candIdx}) : 8'hFF;

  // R5
  ack_vec_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuIrq |-> (ackVector >= 8'(VEC_BASE)) && (ackVector < 8'(VEC_BASE + NUM_LINES)));

  // R6
  nest_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuIrq && svcValid) |-> (ackVector > (8'(VEC_BASE) + {{(8-LINE_W){1'b0}}, svcIdx})));

  // R11
  idle_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cpuIrq |-> (ackVector == 8'hFF));
endmodule

// File: rtl/nic_dp.sv
module nic_dp
  import nic_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int VEC_BASE  = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqLines,
  input  logic [31:0]          regWrData,
  input  ctrlStrobe_t          strobe,
  output logic [31:0]          regRdData,
  output logic                 candValid,
  output logic [LINE_W-1:0]    candIdx,
  output logic                 svcValid,
  output logic [LINE_W-1:0]    svcIdx,
  output logic                 enBit
);
  localparam int VEC_TOP = VEC_BASE + NUM_LINES - 1;

  logic [7:0]           idxReg;
  logic [NUM_LINES-1:0] cfgMask, cfgLevel, linesQ, pendEdge, inService;
  logic [NUM_LINES-1:0] cfgHitVec, riseVec, pendNow, eligible, takeVec, eoiVec;
  logic [LINE_W-1:0]    selLine;
  logic                 idxOk;
  logic                 unusedWr;

  assign unusedWr = ^{regWrData[31:17], regWrData[14:9], regWrData[7:0] ^ 8'(VEC_TOP)};

  function automatic logic [LINE_W:0] pickTop(input logic [NUM_LINES-1:0] v);
    logic [LINE_W:0] r;
    r = '0;
    for (int i = 0; i < NUM_LINES; i++)
      if (v[i]) r = {1'b1, LINE_W'(i)};
    return r;
  endfunction

  assign selLine = {idxReg[6:5], idxReg[3:1]};
  assign idxOk   = !idxReg[0] && !idxReg[4] && !idxReg[7] && (int'(selLine) < NUM_LINES);

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    assign cfgHitVec[n] = strobe.cfgWr && idxOk && (selLine == LINE_W'(n));
    assign riseVec[n]   = irqLines[n] && !linesQ[n] && !cfgMask[n] && !cfgLevel[n];
    assign pendNow[n]   = cfgLevel[n] ? (linesQ[n] && !inService[n]) : pendEdge[n];
    assign eligible[n]  = pendNow[n] && !cfgMask[n];
  end

  assign {candValid, candIdx} = pickTop(eligible);
  assign {svcValid, svcIdx}   = pickTop(inService);

  assign takeVec = strobe.ackTake ? (NUM_LINES'(1) << candIdx) : '0;
  assign eoiVec  = (strobe.eoiWr && svcValid) ? (NUM_LINES'(1) << svcIdx) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxReg    <= '0;
      cfgMask   <= '1;
      cfgLevel  <= '0;
      enBit     <= 1'b0;
      linesQ    <= '0;
      pendEdge  <= '0;
      inService <= '0;
    end else begin
      if (strobe.idxWr) idxReg <= regWrData[7:0];
      if (strobe.enWr)  enBit  <= regWrData[EN_BIT];
      cfgMask   <= (cfgMask  & ~cfgHitVec) | (cfgHitVec & {NUM_LINES{regWrData[CFG_MASK_BIT]}});
      cfgLevel  <= (cfgLevel & ~cfgHitVec) | (cfgHitVec & {NUM_LINES{regWrData[CFG_LEVEL_BIT]}});
      linesQ    <= irqLines;
      pendEdge  <= (pendEdge & ~takeVec) | riseVec;
      inService <= (inService & ~eoiVec) | takeVec;
    end
  end

  always_comb begin
    regRdData = '0;
    unique case (strobe.rdSel)
      RD_INDEX:  regRdData = {24'b0, idxReg};
      RD_WINDOW: if (idxOk) begin
        regRdData[CFG_MASK_BIT]  = cfgMask[selLine];
        regRdData[CFG_LEVEL_BIT] = cfgLevel[selLine];
      end
      RD_ENABLE: regRdData[EN_BIT] = enBit;
      RD_ISR:    regRdData = 32'(inService);
      default: ;
    endcase
  end

  // R5
  ack_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ackTake |=> inService[$past(candIdx)]);

  // R6
  isr_gain_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.ackTake |=> ((inService & ~$past(inService)) == '0));

  // R7
  eoi_retire_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.eoiWr && svcValid && !strobe.ackTake) |=>
      ($countones(inService) == $countones($past(inService)) - 1));

  // R9
  masked_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((pendEdge & ~$past(pendEdge) & $past(cfgMask)) == '0));
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nic_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int VEC_BASE  = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqLines,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [31:0]          regWrData,
  output logic [31:0]          regRdData,
  input  logic                 intAck,
  output logic                 cpuIrq,
  output logic [7:0]           ackVector
);
  ctrlStrobe_t       strobe;
  logic              candValid, svcValid, enBit;
  logic [LINE_W-1:0] candIdx, svcIdx;

  nic_ctrl #(.NUM_LINES(NUM_LINES), .VEC_BASE(VEC_BASE)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .intAck(intAck),
    .candValid(candValid), .candIdx(candIdx), .svcValid(svcValid), .svcIdx(svcIdx),
    .enBit(enBit), .strobe(strobe), .cpuIrq(cpuIrq), .ackVector(ackVector)
  );

  nic_dp #(.NUM_LINES(NUM_LINES), .VEC_BASE(VEC_BASE)) u_dp (
    .clk(clk), .rstN(rstN), .irqLines(irqLines), .regWrData(regWrData), .strobe(strobe),
    .regRdData(regRdData), .candValid(candValid), .candIdx(candIdx),
    .svcValid(svcValid), .svcIdx(svcIdx), .enBit(enBit)
  );
endmodule

// File: tb/sim_nest_irq_ctrl.sv
module sim_nest_irq_ctrl;
  localparam time CLK_P = 20ns;

  logic        clk = 1'b0, rstN = 1'b0;
  logic [31:0] irqLines = '0;
  logic        regWrEn = 1'b0, intAck = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWrData = '0, regRdData;
  logic        cpuIrq;
  logic [7:0]  ackVector;

  int nChecks = 0, nErr = 0;
  bit finished = 0;

  logic [31:0] mMask = '1, mLevel = '0, mLinesQ = '0, mPend = '0, mIsv = '0;
  logic        mEn = 1'b0;
  logic [7:0]  mIdx = '0;

  always #(CLK_P/2) clk = ~clk;

  nest_irq_ctrl u0 (
    .clk(clk), .rstN(rstN), .irqLines(irqLines), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .intAck(intAck),
    .cpuIrq(cpuIrq), .ackVector(ackVector)
  );

  function automatic int topOf(logic [31:0] v);
    int r = -1;
    for (int i = 0; i < 32; i++) if (v[i]) r = i;
    return r;
  endfunction

  function automatic logic [31:0] mElig();
    logic [31:0] e;
    for (int i = 0; i < 32; i++)
      e[i] = (mLevel[i] ? (mLinesQ[i] && !mIsv[i]) : mPend[i]) && !mMask[i];
    return e;
  endfunction

  function automatic logic expReq();
    int c = topOf(mElig());
    return mEn && (c >= 0) && (c > topOf(mIsv));
  endfunction

  function automatic logic [7:0] expVec();
    return expReq() ? 8'(32 + topOf(mElig())) : 8'hFF;
  endfunction

  function automatic logic [7:0] encIdx(int line);
    logic [4:0] l = 5'(line);
    return {1'b0, l[4:3], 1'b0, l[2:0], 1'b0};
  endfunction

  function automatic logic mIdxOk();
    return !mIdx[0] && !mIdx[4] && !mIdx[7];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic modelUpdate();
    logic take;
    int c, s;
    logic [31:0] rise;
    take = intAck && expReq();
    c = topOf(mElig());
    s = topOf(mIsv);
    rise = irqLines & ~mLinesQ & ~mMask & ~mLevel;
    if (take) mPend[c] = 1'b0;
    mPend = mPend | rise;
    if (regWrEn && regAddr == 12'h0B0 && s >= 0) mIsv[s] = 1'b0;
    if (take) mIsv[c] = 1'b1;
    if (regWrEn && regAddr == 12'h010 && mIdxOk()) begin
      mMask[{mIdx[6:5], mIdx[3:1]}]  = regWrData[16];
      mLevel[{mIdx[6:5], mIdx[3:1]}] = regWrData[15];
    end
    if (regWrEn && regAddr == 12'h000) mIdx = regWrData[7:0];
    if (regWrEn && regAddr == 12'h0F0) mEn = regWrData[8];
    mLinesQ = irqLines;
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    modelUpdate();
    @(negedge clk);
    regWrEn = 1'b0;
    intAck  = 1'b0;
    chk(cpuIrq == expReq(), tag, 32'(cpuIrq), 32'(expReq()));
    chk(ackVector == expVec(), tag, 32'(ackVector), 32'(expVec()));
  endtask

  task automatic wrReg(input logic [11:0] a, input logic [31:0] d, input string tag);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    step(tag);
  endtask

  task automatic cfgLine(input int line, input logic [31:0] d, input string tag);
    wrReg(12'h000, 32'(encIdx(line)), tag);
    wrReg(12'h010, d, tag);
  endtask

  task automatic rdCheck(input logic [11:0] a, input logic [31:0] exp, input string tag);
    regAddr = a;
    #1;
    chk(regRdData == exp, tag, regRdData, exp);
  endtask

  task automatic ack(input string tag);
    intAck = 1'b1;
    step(tag);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      nErr++; nChecks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(cpuIrq == 1'b0, "R1", 32'(cpuIrq), 0);
    chk(ackVector == 8'hFF, "R1", 32'(ackVector), 32'hFF);
    rdCheck(12'h110, 32'h0, "R1");
    rdCheck(12'h0F0, 32'h0, "R1");
    for (int n = 0; n < 32; n++) begin
      wrReg(12'h000, 32'(encIdx(n)), "R2");
      rdCheck(12'h000, 32'(encIdx(n)), "R2");
      rdCheck(12'h010, 32'h0001_0000, "R1");
    end

    // R3 layout and dropped bits
    cfgLine(5, 32'hFFFF_FFFF, "R3");
    rdCheck(12'h010, 32'h0001_8000, "R3");
    wrReg(12'h010, 32'h0000_0000, "R3");
    rdCheck(12'h010, 32'h0, "R3");
    // R2 invalid index selects nothing
    wrReg(12'h000, 32'h0B, "R2");
    rdCheck(12'h010, 32'h0, "R2");
    wrReg(12'h010, 32'h0001_8000, "R2");
    wrReg(12'h000, 32'(encIdx(5)), "R2");
    rdCheck(12'h010, 32'h0, "R2");

    // R4 enable gating
    irqLines[5] = 1'b1;
    step("R4");
    chk(cpuIrq == 1'b0, "R4", 32'(cpuIrq), 0);
    ack("R4");
    rdCheck(12'h110, 32'h0, "R4");
    wrReg(12'h0F0, 32'h100, "R4");
    rdCheck(12'h0F0, 32'h100, "R4");
    chk(cpuIrq == 1'b1, "R5", 32'(cpuIrq), 1);
    chk(ackVector == 8'd37, "R5", 32'(ackVector), 37);

    // R5, R6, R7, R10 nesting
    ack("R5");
    chk(cpuIrq == 1'b0, "R5", 32'(cpuIrq), 0);
    rdCheck(12'h110, 32'h20, "R10");
    cfgLine(3, 32'h0, "R6");
    irqLines[3] = 1'b1;
    step("R6");
    chk(cpuIrq == 1'b0, "R6", 32'(cpuIrq), 0);
    cfgLine(9, 32'h0, "R6");
    irqLines[9] = 1'b1;
    step("R6");
    chk(ackVector == 8'd41, "R6", 32'(ackVector), 41);
    ack("R6");
    rdCheck(12'h110, 32'h220, "R10");
    wrReg(12'h0B0, 32'h0, "R7");
    rdCheck(12'h110, 32'h20, "R7");
    chk(cpuIrq == 1'b0, "R7", 32'(cpuIrq), 0);
    wrReg(12'h0B0, 32'hDEAD, "R7");
    rdCheck(12'h110, 32'h0, "R7");
    chk(ackVector == 8'd35, "R7", 32'(ackVector), 35);
    ack("R7");
    wrReg(12'h0B0, 32'h0, "R7");

    // R8 level mode
    cfgLine(12, 32'h0000_8000, "R8");
    irqLines[12] = 1'b1;
    step("R8");
    chk(ackVector == 8'd44, "R8", 32'(ackVector), 44);
    ack("R8");
    chk(cpuIrq == 1'b0, "R8", 32'(cpuIrq), 0);
    wrReg(12'h0B0, 32'h0, "R8");
    chk(ackVector == 8'd44, "R8", 32'(ackVector), 44);
    irqLines[12] = 1'b0;
    step("R8");
    chk(cpuIrq == 1'b0, "R8", 32'(cpuIrq), 0);

    // R9 masked edge not latched
    irqLines[20] = 1'b1;
    step("R9");
    chk(cpuIrq == 1'b0, "R9", 32'(cpuIrq), 0);
    cfgLine(20, 32'h0, "R9");
    chk(cpuIrq == 1'b0, "R9", 32'(cpuIrq), 0);

    // R11 ack without request
    ack("R11");
    rdCheck(12'h110, 32'h0, "R11");
    chk(ackVector == 8'hFF, "R11", 32'(ackVector), 32'hFF);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom % 16);
      irqLines = irqLines ^ ($urandom & $urandom & $urandom & $urandom);
      if (r < 2) begin
        cfgLine(int'($urandom % 32), $urandom, "R3");
      end else if (r == 2) begin
        wrReg(12'h0B0, $urandom, "R7");
      end else if (r < 7) begin
        ack("R5");
      end else begin
        step("R6");
      end
      if (i % 8 == 0) rdCheck(12'h110, mIsv, "R10");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule